// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block collects level-sensitive interrupt lines from up to 64 devices into one shared raw request register and routes them to as many as four CPUs. Every CPU owns a 64-bit enable mask. Its hard-interrupt output is high whenever at least one raw request is set that its mask also enables. A separate legacy cascade line from the bridge to the old peripheral bus is merged into raw bit 55.

Firmware reaches the block through a 64-bit register port that accepts only whole 8-byte accesses. Software writes the masks through this port. Software can also read three kinds of value: the raw register, each mask, and a per-CPU masked view, which is the mask ANDed with the raw register. The masked views and the raw register are read-only.

Each request is answered one cycle later with a response strobe. An access that is illegal or that does not decode returns zero and raises a one-cycle error flag.

Top module: `irq_router`

## Requirements
- R1: After reset, and again after any later reset, all masks and the raw register read zero, every CPU output is low, and the response strobe and error flag are low.
- R2: A device line's level is captured into the raw register bit of the same index at each clock edge. A high level sets the bit and a low level clears it. The raw register reads at offset 0x300.
- R3: Raw bit 55 is set when device line 55 or the cascade input is high.
- R4: A write with all eight byte enables stores the full 64-bit value into a mask. The mask offsets are 0x200 for CPU0, 0x240 for CPU1, 0x600 for CPU2 and 0x640 for CPU3. A read at the same offset returns the stored value.
- R5: A read of a masked view returns that CPU's mask ANDed with the raw register. The view offsets are 0x280 for CPU0, 0x2C0 for CPU1, 0x680 for CPU2 and 0x6C0 for CPU3.
- R6: CPU output c is high exactly when mask c ANDed with the raw register is non-zero. It changes at the same clock edge that updates the mask or the raw bit, so it is visible one clock after the cause.
- R7: Writes to the masked views and to the raw register change nothing and raise no error.
- R8: An access with any byte enable low changes no state, returns zero and raises the error flag.
- R9: An access to an offset outside the mapped set returns zero and raises the error flag for one cycle. Misaligned offsets count as unmapped.
- R10: The response strobe is high for exactly the one cycle after each request. A write responds with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq_i | input | NSRC | Device interrupt levels, one per raw bit |
| cascade_irq_i | input | 1 | Legacy cascade interrupt level, merged into bit 55 |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the register |
| req_be_i | input | 8 | Byte enables; all must be set |
| req_wdata_i | input | 64 | Write data |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_data_o | output | 64 | Read data (zero for writes and errors) |
| rsp_err_o | output | 1 | Error pulse for illegal or unmapped access |
| cpu_irq_o | output | NCPU | Registered hard-interrupt request per CPU |

## Verification
The bench builds the router with its default parameters: 64 sources, four CPUs and the cascade on bit 55. With these values every mask and view offset can be decoded, including the 0x600 bank used by the upper two CPUs. The top raw bit 63 and the cascade merge can also be driven from the ports. Because all four outputs exist at once, the bench can check that a source enabled by one CPU's mask stays invisible to the others.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, access-kind encoding and offset helpers for
// the interrupt router. Assumes at most four CPUs (two banks of two).
package irq_router_pkg;

    localparam int DATA_W  = 64;
    localparam int ADDR_W  = 12;
    localparam int BE_W    = DATA_W / 8;
    localparam int MAX_CPU = 4;

    localparam logic [ADDR_W-1:0] RAW_OFS   = 12'h300;
    localparam int                BANK_STEP = 'h400;
    localparam int                CPU_STEP  = 'h40;
    localparam int                VIEW_GAP  = 'h80;

    // What a decoded register offset selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_VIEW = 2'd2,
        SEL_RAW  = 2'd3
    } sel_kind_e;

    // Offset of the mask register of CPU c.
    function automatic logic [ADDR_W-1:0] mask_ofs(input int c);
        int v;
        v = 'h200 + (c / 2) * BANK_STEP + (c % 2) * CPU_STEP;
        return v[ADDR_W-1:0];
    endfunction

    // Offset of the masked view of CPU c.
    function automatic logic [ADDR_W-1:0] view_ofs(input int c);
        int v;
        v = int'(mask_ofs(c)) + VIEW_GAP;
        return v[ADDR_W-1:0];
    endfunction

endpackage

// File: rtl/irq_raw_capture.sv
// Module: irq_raw_capture
// Samples the device interrupt levels into the shared raw request register
// and merges the legacy cascade line into its assigned bit. Bits above NSRC
// read as zero. Assumes the device levels are already synchronous to clk.
module irq_raw_capture
    import irq_router_pkg::*;
#(
    parameter int NSRC        = 64,
    parameter int CASCADE_BIT = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   dev_irq_i,
    input  logic              cascade_irq_i,
    output logic [DATA_W-1:0] raw_next_o,
    output logic [DATA_W-1:0] raw_o
);

    logic [DATA_W-1:0] raw_q;

    // Build the next raw value bit by bit: live sources, cascade merge, tie-offs.
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (i < NSRC) begin : g_live
            if (i == CASCADE_BIT) begin : g_casc
                assign raw_next_o[i] = dev_irq_i[i] | cascade_irq_i;
            end else begin : g_plain
                assign raw_next_o[i] = dev_irq_i[i];
            end
        end else begin : g_tied
            assign raw_next_o[i] = 1'b0;
        end
    end

    // Capture the raw request register every cycle; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= raw_next_o;
    end

    assign raw_o = raw_q;

    if (CASCADE_BIT < NSRC) begin : g_casc_chk
        p_cascade_sets_r3 : assert property (@(posedge clk) disable iff (!rst_n)
            cascade_irq_i |=> raw_o[CASCADE_BIT])
            else $error("cascade level not reflected in raw bit");
    end

endmodule

// File: rtl/irq_mask_bank.sv
// Module: irq_mask_bank
// Holds one 64-bit enable mask per CPU and the registered hard-interrupt
// output of each. The output is computed from the next mask and next raw
// value, so it tracks the registered state with no added delay.
module irq_mask_bank
    import irq_router_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NCPU-1:0]              we_i,
    input  logic [DATA_W-1:0]            wdata_i,
    input  logic [DATA_W-1:0]            raw_next_i,
    input  logic [DATA_W-1:0]            raw_i,
    output logic [NCPU-1:0][DATA_W-1:0]  mask_o,
    output logic [NCPU-1:0]              irq_o
);

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [DATA_W-1:0] mask_q;
        logic [DATA_W-1:0] mask_nxt;
        logic              irq_q;

        // Select between the held mask and a fresh firmware write.
        always_comb begin
            mask_nxt = we_i[c] ? wdata_i : mask_q;
        end

        // Register the mask and the CPU's request level together.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q <= '0;
                irq_q  <= 1'b0;
            end else begin
                mask_q <= mask_nxt;
                irq_q  <= |(mask_nxt & raw_next_i);
            end
        end

        assign mask_o[c] = mask_q;
        assign irq_o[c]  = irq_q;

        p_irq_level_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            irq_o[c] == |(mask_o[c] & raw_i))
            else $error("cpu output disagrees with mask and raw state");

        p_mask_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            !we_i[c] |=> $stable(mask_o[c]))
            else $error("mask changed without a write enable");
    end

endmodule

// File: rtl/irq_reg_port.sv
// Module: irq_reg_port
// Decodes full-width register accesses, generates mask write enables and
// returns a registered response one cycle after each request. Illegal
// byte enables and unmapped offsets return zero and pulse the error flag.
module irq_reg_port
    import irq_router_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid_i,
    input  logic                         req_write_i,
    input  logic [ADDR_W-1:0]            req_addr_i,
    input  logic [BE_W-1:0]              req_be_i,
    input  logic [NCPU-1:0][DATA_W-1:0]  mask_i,
    input  logic [DATA_W-1:0]            raw_i,
    output logic [NCPU-1:0]              mask_we_o,
    output logic                         rsp_valid_o,
    output logic [DATA_W-1:0]            rsp_data_o,
    output logic                         rsp_err_o
);

    sel_kind_e         kind;
    logic [NCPU-1:0]   mask_hit;
    logic [DATA_W-1:0] rd_sel;
    logic              full_width;
    logic              legal;

    // Decode the offset into an access kind and the value it would read.
    always_comb begin
        kind     = SEL_NONE;
        mask_hit = '0;
        rd_sel   = '0;
        if (req_addr_i == RAW_OFS) begin
            kind   = SEL_RAW;
            rd_sel = raw_i;
        end
        for (int c = 0; c < NCPU; c++) begin
            if (req_addr_i == mask_ofs(c)) begin
                kind        = SEL_MASK;
                mask_hit[c] = 1'b1;
                rd_sel      = mask_i[c];
            end
            if (req_addr_i == view_ofs(c)) begin
                kind   = SEL_VIEW;
                rd_sel = mask_i[c] & raw_i;
            end
        end
    end

    // Qualify the access: full width and a mapped offset.
    always_comb begin
        full_width = &req_be_i;
        legal      = req_valid_i && full_width && (kind != SEL_NONE);
    end

    // Only legal writes to a mask offset reach the mask bank.
    always_comb begin
        mask_we_o = (legal && req_write_i) ? mask_hit : '0;
    end

    // Register the response: strobe, read data and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_data_o  <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_valid_o <= req_valid_i;
            rsp_data_o  <= (legal && !req_write_i) ? rd_sel : '0;
            rsp_err_o   <= req_valid_i && !legal;
        end
    end

    p_rsp_follows_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o)
        else $error("request without response");

    p_rsp_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !rsp_valid_o)
        else $error("response without request");

    p_err_zero_r9 : assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err_o |-> (rsp_data_o == '0) && rsp_valid_o)
        else $error("error response carried data");

    p_partial_no_write_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !(&req_be_i)) |-> (mask_we_o == '0))
        else $error("partial access enabled a mask write");

endmodule

// File: rtl/irq_router.sv
// Module: irq_router (top)
// Routes device interrupt levels to per-CPU hard-interrupt outputs through
// per-CPU masks. Assumes NCPU <= 4, NSRC <= 64 and synchronous sources.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NSRC        = 64,
    parameter int NCPU        = 4,
    parameter int CASCADE_BIT = 55
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   dev_irq_i,
    input  logic              cascade_irq_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [BE_W-1:0]   req_be_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o,
    output logic              rsp_err_o,
    output logic [NCPU-1:0]   cpu_irq_o
);

    logic [DATA_W-1:0]           raw_next;
    logic [DATA_W-1:0]           raw_q;
    logic [NCPU-1:0][DATA_W-1:0] mask_q;
    logic [NCPU-1:0]             mask_we;

    irq_raw_capture #(
        .NSRC        (NSRC),
        .CASCADE_BIT (CASCADE_BIT)
    ) u_capture (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_irq_i     (dev_irq_i),
        .cascade_irq_i (cascade_irq_i),
        .raw_next_o    (raw_next),
        .raw_o         (raw_q)
    );

    irq_mask_bank #(
        .NCPU (NCPU)
    ) u_masks (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (mask_we),
        .wdata_i    (req_wdata_i),
        .raw_next_i (raw_next),
        .raw_i      (raw_q),
        .mask_o     (mask_q),
        .irq_o      (cpu_irq_o)
    );

    irq_reg_port #(
        .NCPU (NCPU)
    ) u_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_be_i    (req_be_i),
        .mask_i      (mask_q),
        .raw_i       (raw_q),
        .mask_we_o   (mask_we),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o),
        .rsp_err_o   (rsp_err_o)
    );

    p_reset_quiet_r1 : assert property (@(posedge clk)
        !rst_n |=> (cpu_irq_o == '0) && !rsp_valid_o && !rsp_err_o)
        else $error("outputs active after reset");

endmodule

// File: tb/irq_router_bench.sv
// Bench: table-driven register and routing checks, then directed tests for
// reset, response timing and output latency.
module irq_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] dev_irq = '0;
    logic        cascade = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_be = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_data;
    logic        rsp_err;
    logic [3:0]  cpu_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_router u_irq_router (
        .clk           (clk),
        .rst_n         (rst_n),
        .dev_irq_i     (dev_irq),
        .cascade_irq_i (cascade),
        .req_valid_i   (req_valid),
        .req_write_i   (req_write),
        .req_addr_i    (req_addr),
        .req_be_i      (req_be),
        .req_wdata_i   (req_wdata),
        .rsp_valid_o   (rsp_valid),
        .rsp_data_o    (rsp_data),
        .rsp_err_o     (rsp_err),
        .cpu_irq_o     (cpu_irq)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [7:0]  be;
        logic [63:0] wdata;
        logic [63:0] src;
        logic        casc;
        logic [63:0] exp_data;
        logic        exp_err;
        logic [3:0]  exp_irq;
        logic [3:0]  rq;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 12'h200, 8'hFF, 64'h00F0, 64'h0, 1'b0, 64'h0, 1'b0, 4'b0000, 4'd4},                                   // R4
        '{1'b0, 12'h200, 8'hFF, 64'h0, 64'h0, 1'b0, 64'h00F0, 1'b0, 4'b0000, 4'd4},                                   // R4
        '{1'b0, 12'h300, 8'hFF, 64'h0, 64'h10, 1'b0, 64'h10, 1'b0, 4'b0001, 4'd2},                                    // R2
        '{1'b0, 12'h280, 8'hFF, 64'h0, 64'h10, 1'b0, 64'h10, 1'b0, 4'b0001, 4'd5},                                    // R5
        '{1'b1, 12'h240, 8'hFF, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0010, 1'b0, 64'h0, 1'b0, 4'b0011, 4'd6}, // R6
        '{1'b1, 12'h600, 8'hFF, 64'h0080_0000_0000_0000, 64'h0, 1'b1, 64'h0, 1'b0, 4'b0100, 4'd3},                    // R3
        '{1'b0, 12'h300, 8'hFF, 64'h0, 64'h0, 1'b1, 64'h0080_0000_0000_0000, 1'b0, 4'b0100, 4'd3},                    // R3
        '{1'b1, 12'h640, 8'hFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b0, 64'h0, 1'b0, 4'b1000, 4'd4},                    // R4
        '{1'b0, 12'h6C0, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h1, 1'b0, 4'b1000, 4'd5},                                      // R5
        '{1'b1, 12'h6C0, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h0, 1'b0, 4'b1000, 4'd7},                                      // R7
        '{1'b0, 12'h640, 8'hFF, 64'h0, 64'h1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b1000, 4'd7},                    // R7
        '{1'b1, 12'h300, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h0, 1'b0, 4'b1000, 4'd7},                                      // R7
        '{1'b0, 12'h300, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h1, 1'b0, 4'b1000, 4'd7},                                      // R7
        '{1'b1, 12'h640, 8'h0F, 64'h0, 64'h1, 1'b0, 64'h0, 1'b1, 4'b1000, 4'd8},                                      // R8
        '{1'b0, 12'h640, 8'hFF, 64'h0, 64'h1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b1000, 4'd8},                    // R8
        '{1'b0, 12'h208, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h0, 1'b1, 4'b1000, 4'd9},                                      // R9
        '{1'b0, 12'h204, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h0, 1'b1, 4'b1000, 4'd9},                                      // R9
        '{1'b0, 12'h600, 8'hFF, 64'h0, 64'h1, 1'b0, 64'h0080_0000_0000_0000, 1'b0, 4'b1000, 4'd4},                    // R4
        '{1'b0, 12'h680, 8'hFF, 64'h0, 64'h0080_0000_0000_0001, 1'b0, 64'h0080_0000_0000_0000, 1'b0, 4'b1100, 4'd5},  // R5
        '{1'b0, 12'h2C0, 8'hFF, 64'h0, 64'h0080_0000_0000_0001, 1'b0, 64'h0, 1'b0, 4'b1100, 4'd5},                    // R5
        '{1'b1, 12'h200, 8'hFF, 64'h0, 64'h0, 1'b0, 64'h0, 1'b0, 4'b0000, 4'd6}                                       // R6
    };

    // Compare one value, count it, and report a mismatch.
    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Issue one request and collect the registered response.
    task automatic access(input logic wr, input logic [11:0] addr, input logic [7:0] be,
                          input logic [63:0] wdata, output logic [63:0] data,
                          output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = addr;
        req_be    = be;
        req_wdata = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        data = rsp_data;
        err  = rsp_err;
        vld  = rsp_valid;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [63:0] d;
        logic        e;
        logic        v;

        repeat (3) @(negedge clk);
        // R1: quiet outputs during and right after reset
        check("R1 irq in reset", {60'h0, cpu_irq}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", {60'h0, cpu_irq}, 64'h0);
        check("R1 err after reset", {63'h0, rsp_err}, 64'h0);
        check("R1 valid after reset", {63'h0, rsp_valid}, 64'h0);
        for (int c = 0; c < 4; c++) begin
            access(1'b0, 12'h200 + 12'((c / 2) * 'h400 + (c % 2) * 'h40), 8'hFF, 64'h0, d, e, v);
            check("R1 mask after reset", d, 64'h0);
        end
        access(1'b0, 12'h300, 8'hFF, 64'h0, d, e, v);
        check("R1 raw after reset", d, 64'h0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            @(negedge clk);
            dev_irq = VEC[i].src;
            cascade = VEC[i].casc;
            access(VEC[i].wr, VEC[i].addr, VEC[i].be, VEC[i].wdata, d, e, v);
            tag = $sformatf("R%0d vector %0d", VEC[i].rq, i);
            check({tag, " data"}, d, VEC[i].exp_data);
            check({tag, " err"}, {63'h0, e}, {63'h0, VEC[i].exp_err});
            check({tag, " valid"}, {63'h0, v}, 64'h1);
            check({tag, " irq"}, {60'h0, cpu_irq}, {60'h0, VEC[i].exp_irq});
        end

        // R10: strobe lasts one cycle; write returns zero data
        access(1'b1, 12'h200, 8'hFF, 64'h1, d, e, v);
        check("R10 write data zero", d, 64'h0);
        check("R10 strobe high", {63'h0, v}, 64'h1);
        @(negedge clk);
        check("R10 strobe drops", {63'h0, rsp_valid}, 64'h0);
        // R9: error flag also lasts one cycle
        access(1'b0, 12'h7F8, 8'hFF, 64'h0, d, e, v);
        check("R9 unmapped err", {63'h0, e}, 64'h1);
        @(negedge clk);
        check("R9 err one cycle", {63'h0, rsp_err}, 64'h0);

        // R6: latency of one clock from source change to output
        @(negedge clk);
        dev_irq = 64'h1;
        check("R6 irq before edge", {60'h0, cpu_irq}, 64'h0);
        @(negedge clk);
        check("R6 irq after edge", {60'h0, cpu_irq}, 64'h9);
        dev_irq = 64'h0;
        @(negedge clk);
        check("R6 irq falls", {60'h0, cpu_irq}, 64'h0);
        // R2: top source bit routes to CPU1 (mask bit 63)
        dev_irq = 64'h8000_0000_0000_0000;
        @(negedge clk);
        check("R2 bit63 routes", {60'h0, cpu_irq}, 64'hA);

        // R1: reset in mid-run clears masks and outputs
        dev_irq = 64'h1;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after re-reset", {60'h0, cpu_irq}, 64'h0);
        access(1'b0, 12'h640, 8'hFF, 64'h0, d, e, v);
        check("R1 mask3 after re-reset", d, 64'h0);
        access(1'b0, 12'h300, 8'hFF, 64'h0, d, e, v);
        check("R2 raw after re-reset", d, 64'h1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule